// File: doc/BRIEF.md
# Instruction Queue Tracking Monitor

This block watches a CPU from the outside and rebuilds, cycle by cycle, the contents of the CPU's instruction prefetch queue. The CPU reports queue activity on a 2-bit status bus that carries two different kinds of code. In the bus-clock high phase the bus tells how the queue moved. In the low phase it tells whether an instruction or an interrupt sequence started. The monitor samples that bus and the 16-bit data bus, and keeps a shadow copy of the queue: a chain of 16-bit stages fed from a separate 16-bit holding latch.

Both bus-clock edges arrive as single-cycle enables on one fast system clock. `e_fall` marks a falling edge of the bus clock. At that edge the data word is captured and the start code is decoded. `e_rise` marks a rising edge. At that edge the movement code is applied to the word captured at the previous falling edge.

For each start, the monitor raises one registered strobe: interrupt, even-aligned or odd-aligned. For an instruction start it also gives the opcode byte taken from the head stage. It flags a fault when the rebuilt queue cannot explain what the CPU reports. A trace unit or a disassembler placed after it uses these outputs.

Top module: `iq_tracker`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every stage and the holding latch are invalid, and `st_irq`, `st_even`, `st_odd`, `fault` and `opcode` are 0.
- R2: `pipe_st` is decoded only in a cycle with `e_rise` or `e_fall` high. When neither is high, no strobe rises in the next cycle and the rebuilt queue is left unchanged. The bench never raises both enables in one cycle.
- R3: Movement code 01 (latch), applied at `e_rise`, loads the holding latch with the data word captured at the latest earlier `e_fall` and marks the latch valid. The stages are not touched.
- R4: Movement code 10 (advance from bus) moves every stage one place toward the head and discards the old head. The last stage is filled, marked valid, with the data word captured at the latest earlier `e_fall`.
- R5: Movement code 11 (advance from latch) advances the stages as in R4, but fills the last stage from the holding latch and gives it the latch's valid bit. The latch then becomes invalid.
- R6: Start code 10 (even start), sampled at `e_fall`, pulses `st_even` in the next cycle. `opcode` then equals bits 15:8 of the head stage as it was before that edge.
- R7: Start code 11 (odd start), sampled at `e_fall`, pulses `st_odd` in the next cycle. `opcode` then equals bits 7:0 of the head stage.
- R8: Start code 01 (interrupt), sampled at `e_fall`, pulses `st_irq` in the next cycle, with `opcode` equal to 0. Start code 00 gives no strobe.
- R9: At most one of `st_irq`, `st_even` and `st_odd` is high in any cycle. `opcode` is 0 in every cycle in which neither `st_even` nor `st_odd` is high.
- R10: `fault` pulses in the cycle after either of two events. One is an even or odd start while the head stage is invalid; in that case `opcode` is 0. The other is an advance from the latch while the latch is invalid; in that case the filled last stage is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| e_rise | input | 1 | One-cycle enable marking a bus-clock rising edge |
| e_fall | input | 1 | One-cycle enable marking a bus-clock falling edge |
| pipe_st | input | 2 | Time-multiplexed queue status code |
| bus_data | input | 16 | CPU data bus |
| st_irq | output | 1 | Interrupt sequence start strobe |
| st_even | output | 1 | Even-aligned instruction start strobe |
| st_odd | output | 1 | Odd-aligned instruction start strobe |
| opcode | output | 8 | Opcode byte of the starting instruction |
| fault | output | 1 | Queue model inconsistency pulse |

## Verification
The bench builds the block with three queue stages instead of the default two. A stage can then hold a word for two advances before it reaches the head, so a wrong shift order or a lost middle stage changes the opcodes that come out. The random phase mixes every movement and start code with junk status values in the idle cycles. This brings into reach advances from an empty latch, starts on an empty head during the fill after reset, and a latched word that waits several advances before it is consumed.

// File: rtl/iqt_pkg.sv
package iqt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MV_NONE     = 2'b00,
    MV_LATCH    = 2'b01,
    MV_ADV_BUS  = 2'b10,
    MV_ADV_HOLD = 2'b11
  } mv_code_e;

  typedef enum logic [1:0] {
    ST_NONE = 2'b00,
    ST_IRQ  = 2'b01,
    ST_EVEN = 2'b10,
    ST_ODD  = 2'b11
  } st_code_e;
endpackage

// File: rtl/iqt_bus_capture.sv
module iqt_bus_capture #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_en,
  input  logic [WORD_W-1:0] bus_in,
  output logic [WORD_W-1:0] bus_word
);
  always_ff @(posedge clk) begin
    if (rst)          bus_word <= '0;
    else if (fall_en) bus_word <= bus_in;
  end
endmodule

// File: rtl/iqt_queue.sv
module iqt_queue
  import iqt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_en,
  input  mv_code_e          mv,
  input  logic [WORD_W-1:0] bus_word,
  output logic [WORD_W-1:0] head_word,
  output logic              head_vld,
  output logic              hold_vld
);
  localparam int LAST = DEPTH - 1;

  logic [WORD_W-1:0] stg_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [WORD_W-1:0] hold_q;
  logic              hold_v_q;
  logic              adv;
  logic [WORD_W-1:0] fill_w;
  logic              fill_v;

  assign adv    = rise_en && (mv == MV_ADV_BUS || mv == MV_ADV_HOLD);
  assign fill_w = (mv == MV_ADV_HOLD) ? hold_q : bus_word;
  assign fill_v = (mv == MV_ADV_HOLD) ? hold_v_q : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      vld_q <= '0;
    end else if (adv) begin
      for (int i = 0; i < LAST; i++) begin
        stg_q[i] <= stg_q[i+1];
        vld_q[i] <= vld_q[i+1];
      end
      stg_q[LAST] <= fill_w;
      vld_q[LAST] <= fill_v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
    end else if (rise_en && mv == MV_LATCH) begin
      hold_q   <= bus_word;
      hold_v_q <= 1'b1;
    end else if (rise_en && mv == MV_ADV_HOLD) begin
      hold_v_q <= 1'b0;
    end
  end

  assign head_word = stg_q[0];
  assign head_vld  = vld_q[0];
  assign hold_vld  = hold_v_q;

  // R3
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_en && mv == MV_LATCH) |=> (hold_v_q && hold_q == $past(bus_word)));
  // R4
  adv_bus_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_en && mv == MV_ADV_BUS) |=> (vld_q[LAST] && stg_q[LAST] == $past(bus_word)));
  // R5
  adv_hold_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_en && mv == MV_ADV_HOLD) |=> !hold_v_q);
  // R2
  idle_queue_chk: assert property (@(posedge clk) disable iff (rst)
    !rise_en |=> ($stable(vld_q) && $stable(hold_v_q)));
endmodule

// File: rtl/iqt_start.sv
module iqt_start
  import iqt_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_en,
  input  logic              rise_en,
  input  st_code_e          st,
  input  mv_code_e          mv,
  input  logic [WORD_W-1:0] head_word,
  input  logic              head_vld,
  input  logic              hold_vld,
  output logic              st_irq,
  output logic              st_even,
  output logic              st_odd,
  output logic [BYTE_W-1:0] opcode,
  output logic              fault
);
  logic start_bad;
  logic drain_bad;

  assign start_bad = fall_en && (st == ST_EVEN || st == ST_ODD) && !head_vld;
  assign drain_bad = rise_en && mv == MV_ADV_HOLD && !hold_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_irq  <= 1'b0;
      st_even <= 1'b0;
      st_odd  <= 1'b0;
      opcode  <= '0;
      fault   <= 1'b0;
    end else begin
      st_irq  <= 1'b0;
      st_even <= 1'b0;
      st_odd  <= 1'b0;
      opcode  <= '0;
      fault   <= start_bad || drain_bad;
      if (fall_en) begin
        unique case (st)
          ST_IRQ:  st_irq <= 1'b1;
          ST_EVEN: begin
            st_even <= 1'b1;
            opcode  <= head_vld ? head_word[WORD_W-1 -: BYTE_W] : '0;
          end
          ST_ODD: begin
            st_odd <= 1'b1;
            opcode <= head_vld ? head_word[BYTE_W-1:0] : '0;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_irq, st_even, st_odd}));
  // R10
  empty_head_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_en && st[1] && !head_vld) |=> (fault && opcode == '0));
endmodule

// File: rtl/iq_tracker.sv
module iq_tracker
  import iqt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_rise,
  input  logic              e_fall,
  input  logic [1:0]        pipe_st,
  input  logic [WORD_W-1:0] bus_data,
  output logic              st_irq,
  output logic              st_even,
  output logic              st_odd,
  output logic [BYTE_W-1:0] opcode,
  output logic              fault
);
  logic [WORD_W-1:0] bus_word;
  logic [WORD_W-1:0] head_word;
  logic              head_vld;
  logic              hold_vld;
  mv_code_e          mv;
  st_code_e          st;

  assign mv = mv_code_e'(pipe_st);
  assign st = st_code_e'(pipe_st);

  iqt_bus_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .fall_en(e_fall), .bus_in(bus_data), .bus_word(bus_word)
  );

  iqt_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .rise_en(e_rise), .mv(mv), .bus_word(bus_word),
    .head_word(head_word), .head_vld(head_vld), .hold_vld(hold_vld)
  );

  iqt_start #(.WORD_W(WORD_W)) u_start (
    .clk(clk), .rst(rst), .fall_en(e_fall), .rise_en(e_rise), .st(st), .mv(mv),
    .head_word(head_word), .head_vld(head_vld), .hold_vld(hold_vld),
    .st_irq(st_irq), .st_even(st_even), .st_odd(st_odd), .opcode(opcode), .fault(fault)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!st_irq && !st_even && !st_odd && !fault && opcode == '0));
  // R2
  no_fall_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    !e_fall |=> (!st_irq && !st_even && !st_odd));
  // R6
  even_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (e_fall && pipe_st == 2'b10) |=> st_even);
  // R7
  odd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (e_fall && pipe_st == 2'b11) |=> st_odd);
  // R8
  irq_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (e_fall && pipe_st == 2'b01) |=> (st_irq && opcode == '0));
endmodule

// File: tb/test_iq_tracker.sv
module test_iq_tracker;
  localparam int WORD_W = 16;
  localparam int DEPTH  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e_rise = 1'b0;
  logic e_fall = 1'b0;
  logic [1:0] pipe_st = 2'b00;
  logic [WORD_W-1:0] bus_data = '0;
  logic st_irq, st_even, st_odd, fault;
  logic [7:0] opcode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iq_tracker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) i_iq_tracker (
    .clk(clk), .rst(rst), .e_rise(e_rise), .e_fall(e_fall), .pipe_st(pipe_st),
    .bus_data(bus_data), .st_irq(st_irq), .st_even(st_even), .st_odd(st_odd),
    .opcode(opcode), .fault(fault)
  );

  // Behavioural reference: queue of words with a parallel queue of valid flags.
  logic [15:0] m_word [$];
  bit          m_ok   [$];
  logic [15:0] m_hold = '0;
  bit          m_hold_ok = 0;
  logic [15:0] m_bus = '0;
  bit x_irq = 0, x_even = 0, x_odd = 0, x_fault = 0;
  logic [7:0] x_op = '0;

  task automatic model_reset();
    m_word.delete(); m_ok.delete();
    for (int i = 0; i < DEPTH; i++) begin m_word.push_back('0); m_ok.push_back(0); end
    m_hold = '0; m_hold_ok = 0; m_bus = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
      x_irq = 0; x_even = 0; x_odd = 0; x_fault = 0; x_op = '0;
    end else begin
      x_irq = 0; x_even = 0; x_odd = 0; x_fault = 0; x_op = '0;
      if (e_fall) begin
        case (pipe_st)
          2'b01: x_irq = 1;                                           // R8
          2'b10: begin x_even = 1; if (m_ok[0]) x_op = m_word[0][15:8]; else x_fault = 1; end // R6
          2'b11: begin x_odd = 1;  if (m_ok[0]) x_op = m_word[0][7:0];  else x_fault = 1; end // R7
          default: ;
        endcase
      end
      if (e_rise) begin
        case (pipe_st)
          2'b01: begin m_hold = m_bus; m_hold_ok = 1; end              // R3
          2'b10: begin void'(m_word.pop_front()); void'(m_ok.pop_front());
                   m_word.push_back(m_bus); m_ok.push_back(1); end      // R4
          2'b11: begin
                   if (!m_hold_ok) x_fault = 1;                         // R10
                   void'(m_word.pop_front()); void'(m_ok.pop_front());
                   m_word.push_back(m_hold); m_ok.push_back(m_hold_ok);
                   m_hold_ok = 0;                                       // R5
                 end
          default: ;
        endcase
      end
      if (e_fall) m_bus = bus_data;
    end
  end

  task automatic check1(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        check1("R1", "strobes", {st_irq, st_even, st_odd}, 0);
        check1("R1", "fault", fault, 0);
      end else begin
        check1("R8", "st_irq", st_irq, x_irq);
        check1("R6", "st_even", st_even, x_even);
        check1("R7", "st_odd", st_odd, x_odd);
        check1("R9", "opcode", opcode, x_op);
        check1("R10", "fault", fault, x_fault);
      end
    end
  end

  // One bus-clock phase: an enable for one cycle, then idle cycles with junk status (R2).
  task automatic phase(input bit fe, input bit re, input logic [1:0] code, input logic [15:0] d);
    @(negedge clk);
    e_fall = fe; e_rise = re; pipe_st = code; bus_data = d;
    @(negedge clk);
    e_fall = 0; e_rise = 0; pipe_st = 2'($urandom); bus_data = 16'($urandom);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1, R10: start on an empty queue right after reset
    phase(1, 0, 2'b10, 16'h1122);
    phase(0, 1, 2'b00, 16'h0);
    // R10: advance from an empty latch
    phase(1, 0, 2'b00, 16'hA1B2);
    phase(0, 1, 2'b11, 16'h0);
    // R4: fill the queue from the bus
    phase(1, 0, 2'b00, 16'hC3D4);
    phase(0, 1, 2'b10, 16'h0);
    phase(1, 0, 2'b00, 16'hE5F6);
    phase(0, 1, 2'b10, 16'h0);
    phase(1, 0, 2'b00, 16'h0718);
    phase(0, 1, 2'b10, 16'h0);
    // R6, R7, R8: starts on a full queue
    phase(1, 0, 2'b10, 16'h293A);
    phase(0, 1, 2'b01, 16'h0);     // R3 latch 293A
    phase(1, 0, 2'b11, 16'h4B5C);
    phase(0, 1, 2'b11, 16'h0);     // R5 advance from latch
    phase(1, 0, 2'b01, 16'h6D7E);
    phase(0, 1, 2'b00, 16'h0);
    // R2: idle cycles with junk codes
    repeat (6) phase(0, 0, 2'b10, 16'hFFFF);
    phase(1, 0, 2'b11, 16'h8F90);
    // Random mix of every code
    for (int n = 0; n < 600; n++) begin
      phase(1, 0, 2'($urandom), 16'($urandom));
      phase(0, 1, 2'($urandom), 16'($urandom));
    end
    // R1: reset in the middle of traffic, then start on the emptied queue
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    phase(1, 0, 2'b11, 16'h1357);
    phase(0, 1, 2'b00, 16'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule